// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a bus-attached watchdog. Software reaches three 32-bit registers: a control word, a running counter and a timeout limit. The counter address does not take a count. It takes magic keys. One key opens a short configuration window. A second key restarts the count from zero. While the counter is enabled it steps once on each tick from a selected tick source. When it reaches the programmed limit, the block drives a one-cycle reset pulse and starts counting again from zero.

The control word chooses how keys are given. In one mode a key is a single 32-bit write. In the other it is two 16-bit writes that must come in a fixed order. A write with the wrong value cancels any half-finished key. Such a write never touches the counter or the configuration. The configuration window lasts a fixed number of bus clocks, or ends early at the first control write. A "permit reconfiguration" bit decides whether the block can ever be unlocked again. If that bit is clear when the window closes, the configuration stays fixed until the next reset.

Top module: `wdt_keyguard`

## Requirements
- R1: After reset the control word reads 0x0000_0020 (only the reconfiguration-permit bit 5 set), the counter reads 0, the limit register reads TOVAL_RST, and the reset output is low.
- R2: Writes to the control word (offset 0x0) or the limit register (offset 0x8) are ignored while the configuration window is closed.
- R3: With bit 13 of the control word set (32-bit key mode), writing 0xD928C520 to offset 0x4 opens the configuration window. The unlocked flag (bit 11) then reads 1, and control and limit writes are accepted.
- R4: With bit 13 clear (16-bit key mode), the unlock key is 0x0000C520 followed by 0x0000D928 at offset 0x4. A first half always starts the sequence again. Any other value cancels it, so the second half alone, or keys given in the wrong order, do nothing. Keys of the other mode have no effect.
- R5: Refresh clears the counter, and the counter reads 0 from the next cycle. The refresh key is 0xB480A602 in 32-bit mode, or 0x0000A602 then 0x0000B480 in 16-bit mode. Refresh works whether the window is open or closed.
- R6: The window closes WIN_CYC cycles after the unlock, or at the first accepted control write, whichever comes first. Later writes are then ignored.
- R7: If bit 5 is 0 when the window closes, every later unlock is ignored until reset. The unlocked flag stays 0 and the completion flag is not cleared.
- R8: While enable (bit 7) is set, the counter steps by one on each cycle in which tick_i[sel] is high, where sel is control bits 9:8. Ticks on other sources, or any tick while enable is clear, leave the counter unchanged.
- R9: The tick that would bring the counter to the limit value clears the counter instead, and wdog_rst_o is high for one cycle after it.
- R10: The completion flag (bit 10) reads 0 in the cycle right after an accepted control write and 1 from the cycle after that. It is cleared by the next unlock that takes effect.
- R11: A write to offset 0x4 that is not a key leaves the counter and the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| tick_i | input | NUM_SRC | Tick strobes of the selectable sources |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The permanent lock is the hardest state to reach from the ports. The stimulus first unlocks in 32-bit mode, then commits a control word with bit 5 clear, which closes the window in that same cycle. A fresh unlock must then fail to raise the unlocked flag, and a limit write must leave the limit unchanged. Expiry of the window by time is reached by letting more than WIN_CYC idle cycles pass after an unlock. The ordering rules of 16-bit keys are driven by interleaving halves, stray words and repeated first halves.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;

  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_CNT   = 4'h4;
  localparam logic [3:0] OFS_TOVAL = 4'h8;

  localparam int B_CMD32 = 13;
  localparam int B_UNL   = 11;
  localparam int B_RCS   = 10;
  localparam int B_SELLO = 8;
  localparam int B_EN    = 7;
  localparam int B_UPD   = 5;

  localparam logic [31:0] KEY_UNLOCK32  = 32'hD928_C520;
  localparam logic [31:0] KEY_REFRESH32 = 32'hB480_A602;
  localparam logic [15:0] KEY_UNL_A = 16'hC520;
  localparam logic [15:0] KEY_UNL_B = 16'hD928;
  localparam logic [15:0] KEY_REF_A = 16'hA602;
  localparam logic [15:0] KEY_REF_B = 16'hB480;

  typedef enum logic [1:0] {
    KS_IDLE     = 2'd0,
    KS_UNL_HALF = 2'd1,
    KS_REF_HALF = 2'd2
  } key_state_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic        mode32,
  input  logic [31:0] data,
  output logic        unlock_hit,
  output logic        refresh_hit
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    unlock_hit  = 1'b0;
    refresh_hit = 1'b0;
    if (key_wr) begin
      if (mode32) begin
        st_d        = KS_IDLE;
        unlock_hit  = (data == KEY_UNLOCK32);
        refresh_hit = (data == KEY_REFRESH32);
      end else if (data == {16'h0, KEY_UNL_A}) begin
        st_d = KS_UNL_HALF;
      end else if (data == {16'h0, KEY_REF_A}) begin
        st_d = KS_REF_HALF;
      end else begin
        st_d        = KS_IDLE;
        unlock_hit  = (st_q == KS_UNL_HALF) && (data == {16'h0, KEY_UNL_B});
        refresh_hit = (st_q == KS_REF_HALF) && (data == {16'h0, KEY_REF_B});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdt_cfg_win.sv
module wdt_cfg_win #(
  parameter int WIN_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic unlock_hit,
  input  logic ctrl_wr,
  input  logic upd_after,
  output logic unlock_eff,
  output logic win_open,
  output logic frozen
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic             open_q, open_d;
  logic             frz_q, frz_d;
  logic [WIN_W-1:0] left_q, left_d;

  assign unlock_eff = unlock_hit && !frz_q;
  assign win_open   = open_q;
  assign frozen     = frz_q;

  always_comb begin
    open_d = open_q;
    frz_d  = frz_q;
    left_d = left_q;
    if (unlock_eff) begin
      open_d = 1'b1;
      left_d = WIN_W'(WIN_CYC - 1);
    end else if (open_q) begin
      if (ctrl_wr || left_q == '0) begin
        open_d = 1'b0;
        frz_d  = !upd_after;
      end else begin
        left_d = left_q - WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      frz_q  <= 1'b0;
      left_q <= '0;
    end else begin
      open_q <= open_d;
      frz_q  <= frz_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W   = 24,
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [NUM_SRC-1:0] tick,
  input  logic             refresh,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             exp_q, exp_d;
  logic             tick_sel;

  assign tick_sel = tick[sel];
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign cnt      = cnt_q;
  assign expire   = exp_q;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (refresh) begin
      cnt_d = '0;
    end else if (en && tick_sel) begin
      if (cnt_inc == limit) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end
endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
  import wdt_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          CNT_W     = 24,
  parameter int          NUM_SRC   = 4,
  parameter int          WIN_CYC   = 128,
  parameter logic [31:0] TOVAL_RST = 32'd60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic              wdog_rst_o
);
  localparam int SEL_W = $clog2(NUM_SRC);

  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  logic             cmd32_q, cmd32_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             en_q, en_d;
  logic             upd_q, upd_d;
  logic             rcs_q, rcs_d;
  logic             wr_seen_q;
  logic [CNT_W-1:0] toval_q, toval_d;

  logic key_wr, ctrl_wr, toval_wr, upd_after;
  logic unlock_hit, refresh_hit, unlock_eff, win_open, frozen;
  logic [CNT_W-1:0] cnt;

  assign key_wr   = wr_en && (wr_addr == ADDR_W'(OFS_CNT));
  assign ctrl_wr  = wr_en && win_open && (wr_addr == ADDR_W'(OFS_CTRL));
  assign toval_wr = wr_en && win_open && (wr_addr == ADDR_W'(OFS_TOVAL));
  assign upd_after = ctrl_wr ? wr_data[B_UPD] : upd_q;

  wdt_key_seq u_keys (
    .clk(clk), .rst_n(rst_s_n), .key_wr(key_wr), .mode32(cmd32_q),
    .data(wr_data), .unlock_hit(unlock_hit), .refresh_hit(refresh_hit)
  );

  wdt_cfg_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_s_n), .unlock_hit(unlock_hit), .ctrl_wr(ctrl_wr),
    .upd_after(upd_after), .unlock_eff(unlock_eff), .win_open(win_open),
    .frozen(frozen)
  );

  wdt_counter #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .en(en_q), .sel(sel_q), .tick(tick_i),
    .refresh(refresh_hit), .limit(toval_q), .cnt(cnt), .expire(wdog_rst_o)
  );

  always_comb begin
    cmd32_d = cmd32_q;
    sel_d   = sel_q;
    en_d    = en_q;
    upd_d   = upd_q;
    toval_d = toval_q;
    rcs_d   = rcs_q;
    if (ctrl_wr) begin
      cmd32_d = wr_data[B_CMD32];
      sel_d   = wr_data[B_SELLO +: SEL_W];
      en_d    = wr_data[B_EN];
      upd_d   = wr_data[B_UPD];
    end
    if (toval_wr) toval_d = wr_data[CNT_W-1:0];
    if (unlock_eff)     rcs_d = 1'b0;
    else if (wr_seen_q) rcs_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cmd32_q   <= 1'b0;
      sel_q     <= '0;
      en_q      <= 1'b0;
      upd_q     <= 1'b1;
      rcs_q     <= 1'b0;
      wr_seen_q <= 1'b0;
      toval_q   <= TOVAL_RST[CNT_W-1:0];
    end else begin
      cmd32_q   <= cmd32_d;
      sel_q     <= sel_d;
      en_q      <= en_d;
      upd_q     <= upd_d;
      rcs_q     <= rcs_d;
      wr_seen_q <= ctrl_wr;
      toval_q   <= toval_d;
    end
  end

  logic [31:0] ctrl_word;
  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[B_CMD32]             = cmd32_q;
    ctrl_word[B_UNL]               = win_open;
    ctrl_word[B_RCS]               = rcs_q;
    ctrl_word[B_SELLO +: SEL_W]    = sel_q;
    ctrl_word[B_EN]                = en_q;
    ctrl_word[B_UPD]               = upd_q;
    case (rd_addr)
      ADDR_W'(OFS_CTRL):  rd_data = ctrl_word;
      ADDR_W'(OFS_CNT):   rd_data = 32'(cnt);
      ADDR_W'(OFS_TOVAL): rd_data = 32'(toval_q);
      default:            rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyguard_chk.sv
module wdt_keyguard_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             win_open,
  input logic             frozen,
  input logic             ctrl_wr,
  input logic             refresh_hit,
  input logic             en,
  input logic             rcs,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] toval,
  input logic             wdog_rst
);
  assert_locked_limit_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !win_open |=> $stable(toval));

  assert_refresh_clear_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    refresh_hit |=> (cnt == '0));

  assert_ctrl_closes_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (win_open && ctrl_wr) |=> !win_open);

  assert_frozen_stays_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    frozen |=> (frozen && !win_open));

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (!en && !refresh_hit) |=> $stable(cnt));

  assert_expire_clears_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    wdog_rst |-> (cnt == '0));

  assert_rcs_source_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(rcs) |-> $past(ctrl_wr, 2));
endmodule

bind wdt_keyguard wdt_keyguard_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_ok(rst_s_n), .win_open(win_open), .frozen(frozen),
  .ctrl_wr(ctrl_wr), .refresh_hit(refresh_hit), .en(en_q), .rcs(rcs_q),
  .cnt(cnt), .toval(toval_q), .wdog_rst(wdog_rst_o)
);

// File: tb/wdt_keyguard_tb_top.sv
module wdt_keyguard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  tick_i = '0;
  logic        wdog_rst_o;

  int n_checks = 0;
  int n_errors = 0;
  int rst_pulses = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_keyguard #(.WIN_CYC(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_i(tick_i), .wdog_rst_o(wdog_rst_o)
  );

  logic [31:0] q_exp[$];
  logic [3:0]  q_addr[$];
  string       q_req[$];

  always @(negedge clk) begin
    if (wdog_rst_o) rst_pulses++;
    if (q_exp.size() != 0) begin
      logic [31:0] e;
      logic [3:0]  a;
      string       r;
      e = q_exp.pop_front();
      a = q_addr.pop_front();
      r = q_req.pop_front();
      n_checks++;
      if (rd_data !== e) begin
        n_errors++;
        $display("FAIL %s: offset %h actual %h expected %h", r, a, rd_data, e);
      end
    end
  end

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string r);
    rd_addr = a;
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_req.push_back(r);
    @(negedge clk); #1;
  endtask

  task automatic expect_int(input int act, input int exp_v, input string r);
    n_checks++;
    if (act != exp_v) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp_v);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ticks(input logic [3:0] mask, input int n);
    @(posedge clk); #1;
    tick_i = mask;
    repeat (n) @(posedge clk);
    #1 tick_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    expect_rd(4'h0, 32'h0000_0020, "R1 ctrl");
    expect_rd(4'h4, 32'd0, "R1 counter");
    expect_rd(4'h8, 32'd60000, "R1 limit");
    expect_int(int'(wdog_rst_o), 0, "R1 reset out");

    // R2 locked writes
    bus_wr(4'h8, 32'd5);
    expect_rd(4'h8, 32'd60000, "R2 limit locked");
    bus_wr(4'h0, 32'h0000_21A0);
    expect_rd(4'h0, 32'h0000_0020, "R2 ctrl locked");

    // R4 wrong order / cancel; R11 stray word
    bus_wr(4'h4, 32'h0000_D928);
    bus_wr(4'h4, 32'h0000_C520);
    bus_wr(4'h4, 32'h0000_1234);
    bus_wr(4'h4, 32'h0000_D928);
    expect_rd(4'h0, 32'h0000_0020, "R4 cancelled sequence");
    expect_rd(4'h4, 32'd0, "R11 stray key word");
    bus_wr(4'h4, 32'hD928_C520);
    expect_rd(4'h0, 32'h0000_0020, "R4 32-bit key in 16-bit mode");

    // R4 valid 16-bit unlock, R3 accepted writes
    bus_wr(4'h4, 32'h0000_C520);
    bus_wr(4'h4, 32'h0000_D928);
    expect_rd(4'h0, 32'h0000_0820, "R4 unlocked");
    bus_wr(4'h8, 32'd5);
    expect_rd(4'h8, 32'd5, "R3 limit accepted");
    bus_wr(4'h0, 32'h0000_21A0);
    expect_rd(4'h0, 32'h0000_21A0, "R6 window closed by ctrl write, R10 flag not yet set");
    expect_rd(4'h0, 32'h0000_25A0, "R10 completion flag set");

    // R8 tick selection
    ticks(4'b0010, 3);
    expect_rd(4'h4, 32'd3, "R8 selected source counts");
    ticks(4'b1101, 3);
    expect_rd(4'h4, 32'd3, "R8 other sources ignored");

    // R5 refresh 32-bit while locked
    bus_wr(4'h4, 32'hB480_A602);
    expect_rd(4'h4, 32'd0, "R5 32-bit refresh");
    ticks(4'b0010, 2);
    bus_wr(4'h4, 32'h0000_A602);
    bus_wr(4'h4, 32'h0000_B480);
    expect_rd(4'h4, 32'd2, "R5 16-bit refresh in 32-bit mode");
    bus_wr(4'h0, 32'h0000_0000);
    expect_rd(4'h0, 32'h0000_25A0, "R2 ctrl still locked");

    // R9 expiry at limit 5
    ticks(4'b0010, 3);
    expect_rd(4'h4, 32'd0, "R9 counter cleared on expiry");
    expect_int(rst_pulses, 1, "R9 one reset pulse");
    ticks(4'b0010, 4);
    expect_rd(4'h4, 32'd4, "R9 counting resumes from zero");
    expect_int(rst_pulses, 1, "R9 no extra pulse");

    // R3 32-bit unlock, R6 timed expiry
    bus_wr(4'h4, 32'hD928_C520);
    expect_rd(4'h0, 32'h0000_29A0, "R3 unlock flag, R10 flag cleared");
    repeat (WIN + 2) @(posedge clk);
    #1;
    bus_wr(4'h8, 32'd9);
    expect_rd(4'h8, 32'd5, "R6 limit write after window expiry");
    expect_rd(4'h0, 32'h0000_21A0, "R6 flag dropped after expiry");

    // R7 permanent lock
    bus_wr(4'h4, 32'hD928_C520);
    bus_wr(4'h0, 32'h0000_2100);
    expect_rd(4'h0, 32'h0000_2100, "R7 update bit cleared");
    bus_wr(4'h4, 32'hD928_C520);
    expect_rd(4'h0, 32'h0000_2500, "R7 unlock ignored when frozen");
    bus_wr(4'h8, 32'd9);
    expect_rd(4'h8, 32'd5, "R7 limit frozen");
    ticks(4'b1111, 3);
    expect_rd(4'h4, 32'd4, "R8 hold while disabled");

    // back to reset, 16-bit mode details
    do_reset();
    expect_rd(4'h0, 32'h0000_0020, "R1 ctrl after second reset");
    bus_wr(4'h4, 32'h0000_C520);
    bus_wr(4'h4, 32'h0000_C520);
    bus_wr(4'h4, 32'h0000_D928);
    expect_rd(4'h0, 32'h0000_0820, "R4 repeated first half restarts");
    bus_wr(4'h0, 32'h0000_00A0);
    ticks(4'b0001, 2);
    expect_rd(4'h4, 32'd2, "R8 source 0 counts");
    bus_wr(4'h4, 32'h0000_0002);
    expect_rd(4'h4, 32'd2, "R11 plain write to counter");
    bus_wr(4'h4, 32'hB480_A602);
    expect_rd(4'h4, 32'd2, "R5 32-bit refresh in 16-bit mode");
    bus_wr(4'h4, 32'h0000_A602);
    bus_wr(4'h4, 32'h0000_B480);
    expect_rd(4'h4, 32'd0, "R5 16-bit refresh");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule